// File: doc/BRIEF.md
# Eight-Output Addressable Bit Latch

The block keeps a bank of eight output bits that a single data bit, a three-bit address and two active-low controls (a clear control and an enable control) update. The pair of controls picks one of four modes. In the write mode the data bit goes into the addressed output and the rest keep their values. The hold mode freezes every output. The demultiplexer mode drives the data bit onto the addressed output and zeroes the other seven. The clear mode forces every output low.

All modes take effect on the rising clock edge, and the outputs come straight from a register. A synchronous active-high reset zeroes the bank and overrides both controls. The number of outputs is a parameter, and the address width follows from it. An optional checker, chosen by a parameter, watches that the address stays steady across back-to-back write-mode cycles.

Top module: `sel_bit_bank`

## Requirements
- R1: When `rst` is high at a rising edge, all outputs are 0 after that edge, whatever the controls, data and address are.
- R2: With `clr_n`=1 and `en_n`=0 (write mode), the output selected by `sel` takes `din` at the edge. Every other output keeps its value.
- R3: With `clr_n`=1 and `en_n`=1 (hold mode), no output changes at the edge, whatever `din` and `sel` are.
- R4: With `clr_n`=0 and `en_n`=0 (demultiplexer mode), the selected output takes `din` and the other outputs become 0.
- R5: With `clr_n`=0 and `en_n`=1 (clear mode), all outputs become 0, whatever `din` and `sel` are.
- R6: `sel` is an unsigned binary index with bit 0 as the least significant bit. The value k selects output bit `q[k]`.
- R7: When the block moves from demultiplexer mode to hold mode, it keeps the pattern from the last demultiplexer cycle, and at most one bit of that pattern is set.
- R8: When write mode lasts for several consecutive cycles, `sel` must stay unchanged. The addressed output then follows `din` on every cycle, and the optional checker reports any change of `sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Clear control, active low |
| en_n | input | 1 | Enable control, active low |
| din | input | 1 | Data bit |
| sel | input | 3 | Output address (ADDR_W) |
| q | output | 8 | Registered output bank (NUM_OUT) |

## Verification
Two functions can act in the same cycle: a synchronous reset can arrive together with a write-mode or demultiplexer-mode command. The directed sequence and the random stream both raise `rst` together with an active write or demultiplexer command, and the bench judges the result against a reference in which reset takes priority, so an all-zero bank is expected. A demultiplexer cycle followed by hold cycles is also checked, which confirms that the one-hot pattern survives into hold mode while the address and data keep changing.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

   // Operating mode derived from {clr_n, en_n}
   typedef enum logic [1:0] {
      MD_DEMUX = 2'b00,
      MD_CLEAR = 2'b01,
      MD_WRITE = 2'b10,
      MD_HOLD  = 2'b11
   } sbb_mode_t;

endpackage

// File: rtl/sbb_mode_dec.sv
module sbb_mode_dec
   import sbb_pkg::*;
(
   input  logic      clr_n,
   input  logic      en_n,
   output sbb_mode_t mode
);

   always_comb begin
      unique case ({clr_n, en_n})
         2'b10:   mode = MD_WRITE;
         2'b11:   mode = MD_HOLD;
         2'b00:   mode = MD_DEMUX;
         default: mode = MD_CLEAR;
      endcase
   end

endmodule

// File: rtl/sbb_addr_dec.sv
module sbb_addr_dec #(
   parameter int NUM_OUT = 8,
   localparam int ADDR_W = $clog2(NUM_OUT)
) (
   input  logic [ADDR_W-1:0]  sel,
   output logic [NUM_OUT-1:0] hit
);

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_hit
      assign hit[i] = (sel == ADDR_W'(i));
   end

endmodule

// File: rtl/sbb_store.sv
module sbb_store
   import sbb_pkg::*;
#(
   parameter int NUM_OUT = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  sbb_mode_t          mode,
   input  logic               din,
   input  logic [NUM_OUT-1:0] hit,
   output logic [NUM_OUT-1:0] q
);

   logic [NUM_OUT-1:0] q_nxt;

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
      always_comb begin
         unique case (mode)
            MD_WRITE: q_nxt[i] = hit[i] ? din : q[i];
            MD_HOLD:  q_nxt[i] = q[i];
            MD_DEMUX: q_nxt[i] = hit[i] & din;
            default:  q_nxt[i] = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= q_nxt;
   end

endmodule

// File: rtl/sel_bit_bank.sv
module sel_bit_bank
   import sbb_pkg::*;
#(
   parameter int NUM_OUT         = 8,
   parameter bit CHK_ADDR_STABLE = 1'b1,
   localparam int ADDR_W = $clog2(NUM_OUT)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clr_n,
   input  logic               en_n,
   input  logic               din,
   input  logic [ADDR_W-1:0]  sel,
   output logic [NUM_OUT-1:0] q
);

   if (NUM_OUT < 2) begin : g_bad_small
      $error("sel_bit_bank: NUM_OUT must be at least 2");
   end
   if ((1 << ADDR_W) != NUM_OUT) begin : g_bad_pow2
      $error("sel_bit_bank: NUM_OUT must be a power of two");
   end

   sbb_mode_t          mode;
   logic [NUM_OUT-1:0] hit;

   sbb_mode_dec u_mode (
      .clr_n (clr_n),
      .en_n  (en_n),
      .mode  (mode)
   );

   sbb_addr_dec #(.NUM_OUT(NUM_OUT)) u_addr (
      .sel (sel),
      .hit (hit)
   );

   sbb_store #(.NUM_OUT(NUM_OUT)) u_store (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .din  (din),
      .hit  (hit),
      .q    (q)
   );

   // Guards next to the storage
   AST_RESET_ZERO: assert property (@(posedge clk)
      rst |=> (q == '0)); // R1
   AST_WRITE_HIT: assert property (@(posedge clk) disable iff (rst)
      (mode == MD_WRITE) |=> (q[$past(sel)] == $past(din))); // R2
   AST_WRITE_OTHERS: assert property (@(posedge clk) disable iff (rst)
      (mode == MD_WRITE) |=> (((q ^ $past(q)) & ~$past(hit)) == '0)); // R2
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (mode == MD_HOLD) |=> $stable(q)); // R3
   AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      (mode == MD_DEMUX) |=> ($onehot0(q) && (q[$past(sel)] == $past(din)))); // R4
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
      (mode == MD_CLEAR) |=> (q == '0)); // R5

   // Optional address-stability checker for back-to-back write cycles
   if (CHK_ADDR_STABLE) begin : g_addr_chk
      logic              prev_write;
      logic [ADDR_W-1:0] prev_sel;
      always_ff @(posedge clk) begin
         if (rst) prev_write <= 1'b0;
         else     prev_write <= (mode == MD_WRITE);
         prev_sel <= sel;
      end
      AST_SEL_STEADY: assert property (@(posedge clk) disable iff (rst)
         (prev_write && mode == MD_WRITE) |-> (sel == prev_sel)); // R8
   end

endmodule

// File: tb/sel_bit_bank_tb_top.sv
module sel_bit_bank_tb_top;

   localparam int N  = 8;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          clr_n = 1'b1;
   logic          en_n = 1'b1;
   logic          din = 1'b0;
   logic [AW-1:0] sel = '0;
   logic [N-1:0]  q;

   int n_chk  = 0;
   int n_fail = 0;
   logic [N-1:0] model = '0;
   bit prev_wr = 1'b0;

   always #4 clk = ~clk;

   sel_bit_bank #(.NUM_OUT(N)) dut_i (
      .clk   (clk),
      .rst   (rst),
      .clr_n (clr_n),
      .en_n  (en_n),
      .din   (din),
      .sel   (sel),
      .q     (q)
   );

   // Behavioural reference of the mode table
   function automatic logic [N-1:0] ref_next(input logic [N-1:0] cur, input bit r,
                                             input bit cn, input bit en,
                                             input bit d, input int a);
      logic [N-1:0] nx;
      nx = cur;
      if (r) nx = '0;
      else if (cn && !en) nx[a] = d;
      else if (cn && en) nx = cur;
      else if (!cn && !en) begin nx = '0; nx[a] = d; end
      else nx = '0;
      return nx;
   endfunction

   function automatic string tag_of(input bit r, input bit cn, input bit en);
      if (r) return "R1";
      if (cn && !en) return "R2";
      if (cn && en) return "R3";
      if (!cn && !en) return "R4";
      return "R5";
   endfunction

   task automatic step(input bit r, input bit cn, input bit en, input bit d,
                       input int a, input string tag);
      logic [N-1:0] exp_q;
      @(negedge clk);
      rst = r; clr_n = cn; en_n = en; din = d; sel = AW'(a);
      exp_q = ref_next(model, r, cn, en, d, a);
      @(posedge clk);
      #1;
      n_chk++;
      if (q !== exp_q) begin
         n_fail++;
         $display("FAIL %s: q=%b expected %b", tag, q, exp_q);
      end
      model = exp_q;
      prev_wr = !r && cn && !en;
   endtask

   task automatic check_onehot(input string tag);
      n_chk++;
      if ($countones(q) > 1) begin
         n_fail++;
         $display("FAIL %s: q=%b expected at most one set bit", tag, q);
      end
   endtask

   initial begin : watchdog
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      // R1: reset state, reset beats a write command in the same cycle
      step(1, 1, 0, 1, 3, "R1");
      step(1, 0, 0, 1, 6, "R1");
      // R6: each address sets its own bit, hold cycles between writes
      for (int k = 0; k < N; k++) begin
         step(0, 1, 0, 1, k, "R6");
         step(0, 1, 1, ~k[0], (k + 5) % N, "R3");
      end
      // R2: clear one bit by a write of 0
      step(0, 1, 0, 0, 5, "R2");
      step(0, 1, 1, 1, 2, "R3");
      // R8: consecutive writes, same address, data toggles
      step(0, 1, 0, 0, 4, "R8");
      step(0, 1, 0, 1, 4, "R8");
      step(0, 1, 0, 0, 4, "R8");
      step(0, 1, 1, 0, 0, "R3");
      // R4: demultiplexer patterns
      step(0, 0, 0, 1, 6, "R4");
      step(0, 0, 0, 0, 6, "R4");
      step(0, 0, 0, 1, 2, "R4");
      // R7: pattern kept into hold while inputs wiggle
      step(0, 1, 1, 0, 7, "R7");
      check_onehot("R7");
      step(0, 1, 1, 1, 1, "R7");
      check_onehot("R7");
      // R5: clear regardless of inputs
      step(0, 1, 0, 1, 7, "R2");
      step(0, 0, 1, 1, 7, "R5");
      step(0, 0, 1, 0, 0, "R5");
      // R1: reset after a populated bank, together with demux command
      step(0, 1, 0, 1, 1, "R2");
      step(1, 0, 0, 1, 1, "R1");
      // Random stream honouring the address rule of R8
      for (int i = 0; i < 3000; i++) begin
         bit r, cn, en, d;
         int a;
         r  = ($urandom_range(0, 40) == 0);
         cn = $urandom_range(0, 1);
         en = $urandom_range(0, 1);
         d  = $urandom_range(0, 1);
         a  = $urandom_range(0, N - 1);
         if (prev_wr && cn && !en) a = int'(sel);
         step(r, cn, en, d, a, tag_of(r, cn, en));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule